// File: doc/BRIEF.md
# Segment-Control Address Translation Unit

This block turns a 32-bit virtual address into a physical address under a programmable segment scheme. Software divides the address space into six segments and gives each one a 16-bit configuration word, packed two to a register across three 32-bit configuration inputs. Each word carries a physical base field, a 3-bit access-mode code and an error-level override bit. For a given address and privilege mode, the unit picks the word for the addressed segment. It decodes the access mode against a per-privilege table and reports one of three outcomes. An address error means the access is illegal. A TLB request means the page tables must resolve the address, and this block only raises the hand-off. A match means the segment is unmapped: the unit then returns the physical address together with full read, write and execute permission.

The translation logic itself is combinational. A parameter chooses whether the result leaves through a one-stage output register or straight from the logic. Segment boundaries are fixed by the address bits, while each segment's privilege and mapping behaviour is set entirely by its configuration word.

Top module: `seg_xlate_unit`

## Requirements
- R1: An address with bit 31 clear uses `seg_cfg2`: bits [15:0] when address bit 30 is set, bits [31:16] when it is clear, with offset mask 0x3FFFFFFF.
- R2: An address with bit 31 set is selected by address bits [30:29]. The code 00 selects `seg_cfg1[31:16]`, 01 selects `seg_cfg1[15:0]`, 10 selects `seg_cfg0[31:16]` and 11 selects `seg_cfg0[15:0]`. All four use offset mask 0x1FFFFFFF.
- R3: In a 16-bit configuration word, the physical base field is bits [15:9], the access mode is bits [6:4] and the override bit is bit 3. Bits [8:7] and [2:0] have no effect on any output.
- R4: Privilege code 0 (kernel) never gives an address error. Access modes 1, 2 and 3 give a TLB request, and every other mode gives a match.
- R5: Privilege code 1 (supervisor) gives an address error for access modes 0 and 1, a TLB request for modes 2, 3 and 4, and a match for modes 5, 6 and 7.
- R6: Privilege code 2 (user) gives an address error for access modes 0, 1, 2 and 5, a TLB request for modes 3 and 4, and a match for modes 6 and 7.
- R7: Privilege code 3 (error level) gives a match whenever the override bit is set. When the override bit is clear, it follows the kernel rules of R4.
- R8: Access mode 6 gives a match under every privilege code and override value.
- R9: On a match (result code 0), the physical address is computed as follows. The base field is shifted left by 29 and the offset-mask bits are cleared. This is ORed with the virtual address ANDed with the offset mask. `perm_rwx` is 3'b111, with bit 0 = read, bit 1 = write and bit 2 = execute.
- R10: A TLB request is result code 1 and an address error is result code 2. For either one, `phys_addr` is zero and `perm_rwx` is 3'b000.
- R11: With the output register on, `out_valid` and the result appear exactly one cycle after each `in_valid` cycle, with no input dropped under back-to-back traffic. A cycle without `in_valid` gives `out_valid` low and all other outputs zero.
- R12: While reset is held and just after it, `out_valid`, `result`, `phys_addr` and `perm_rwx` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Translation request strobe |
| virt_addr | input | 32 | Virtual address |
| priv_mode | input | 2 | 0 kernel, 1 supervisor, 2 user, 3 error level |
| seg_cfg0 | input | 32 | Configuration for the top two segments |
| seg_cfg1 | input | 32 | Configuration for the two middle upper segments |
| seg_cfg2 | input | 32 | Configuration for the two lower segments |
| out_valid | output | 1 | Result strobe |
| result | output | 2 | 0 match, 1 TLB request, 2 address error |
| phys_addr | output | PA_W (36) | Physical address on a match |
| perm_rwx | output | 3 | Granted permissions, bit 0 read, bit 1 write, bit 2 execute |

## Verification
A wrong segment selection shows up at the ports on the very next result. It appears either as a wrong outcome code or as a physical address whose upper bits come from the wrong base field. A wrong decode-table entry appears on the first request that combines that privilege code with that access mode, so the bench sweeps every pairing and compares each cycle. A stuck or misaligned output register shows as a valid strobe or result that is one cycle late or missing, and it is caught within one cycle of the affected request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      PRIV_KERN   = 2'd0,
      PRIV_SUPER  = 2'd1,
      PRIV_USER   = 2'd2,
      PRIV_ERRLVL = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      XR_MATCH   = 2'd0,
      XR_TLB     = 2'd1,
      XR_ADDRERR = 2'd2
   } xres_e;

   localparam int CFG_W    = 16;
   localparam int PAF_LSB  = 9;
   localparam int PAF_W    = 7;
   localparam int AM_LSB   = 4;
   localparam int AM_W     = 3;
   localparam int EU_BIT   = 3;
   localparam int PA_SHIFT = 29;
   localparam int VA_W     = 32;

   localparam logic [VA_W-1:0] LOW_MASK  = 32'h3FFF_FFFF;
   localparam logic [VA_W-1:0] HIGH_MASK = 32'h1FFF_FFFF;

   localparam logic [AM_W-1:0] AM_RSVD = 3'd6;

endpackage

// File: rtl/seg_cfg_select.sv
module seg_cfg_select
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [31:0]       cfg0,
   input  logic [31:0]       cfg1,
   input  logic [31:0]       cfg2,
   output logic [CFG_W-1:0]  cfg_word,
   output logic [ADDR_W-1:0] off_mask
);

   logic [2:0] top_bits;
   assign top_bits = va[ADDR_W-1 -: 3];

   always_comb begin
      cfg_word = '0;
      off_mask = HIGH_MASK;
      if (!top_bits[2]) begin
         off_mask = LOW_MASK;
         cfg_word = top_bits[1] ? cfg2[15:0] : cfg2[31:16];
      end else begin
         unique case (top_bits[1:0])
            2'b00:   cfg_word = cfg1[31:16];
            2'b01:   cfg_word = cfg1[15:0];
            2'b10:   cfg_word = cfg0[31:16];
            default: cfg_word = cfg0[15:0];
         endcase
      end
   end

endmodule

// File: rtl/seg_am_decode.sv
module seg_am_decode
   import seg_xlate_pkg::*;
(
   input  logic [1:0]      priv,
   input  logic [AM_W-1:0] am,
   input  logic            eu,
   output xres_e           res
);

   localparam logic [7:0] KERN_MAP = 8'b0000_1110;
   localparam logic [7:0] SUP_ADE  = 8'b0000_0011;
   localparam logic [7:0] SUP_MAP  = 8'b0001_1100;
   localparam logic [7:0] USR_ADE  = 8'b0010_0111;
   localparam logic [7:0] USR_MAP  = 8'b0001_1000;

   logic [7:0] ade_vec;
   logic [7:0] map_vec;

   always_comb begin
      ade_vec = '0;
      map_vec = '0;
      unique case (priv_e'(priv))
         PRIV_KERN:  map_vec = KERN_MAP;
         PRIV_SUPER: begin ade_vec = SUP_ADE; map_vec = SUP_MAP; end
         PRIV_USER:  begin ade_vec = USR_ADE; map_vec = USR_MAP; end
         default:    map_vec = eu ? 8'h00 : KERN_MAP;
      endcase
   end

   always_comb begin
      if (ade_vec[am])      res = XR_ADDRERR;
      else if (map_vec[am]) res = XR_TLB;
      else                  res = XR_MATCH;
   end

   // R8: reserved code never errors or maps
   always_comb begin
      if (am == AM_RSVD)
         a_r8_rsvd_match: assert (res == XR_MATCH);
   end

endmodule

// File: rtl/seg_pa_compose.sv
module seg_pa_compose
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PA_W   = 36
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [ADDR_W-1:0] off_mask,
   input  logic [PAF_W-1:0]  pa_field,
   input  xres_e             res,
   output logic [PA_W-1:0]   pa,
   output logic [2:0]        perm
);

   logic [PA_W-1:0] base_ext;
   logic [PA_W-1:0] mask_ext;
   logic [PA_W-1:0] va_ext;

   assign base_ext = PA_W'(pa_field) << PA_SHIFT;
   assign mask_ext = PA_W'(off_mask);
   assign va_ext   = PA_W'(va);

   always_comb begin
      if (res == XR_MATCH) begin
         pa   = (base_ext & ~mask_ext) | (va_ext & mask_ext);
         perm = 3'b111;
      end else begin
         pa   = '0;
         perm = 3'b000;
      end
   end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int PA_W    = 36,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] virt_addr,
   input  logic [1:0]        priv_mode,
   input  logic [31:0]       seg_cfg0,
   input  logic [31:0]       seg_cfg1,
   input  logic [31:0]       seg_cfg2,
   output logic              out_valid,
   output logic [1:0]        result,
   output logic [PA_W-1:0]   phys_addr,
   output logic [2:0]        perm_rwx
);

   localparam int MIN_PA_W = PAF_W + PA_SHIFT;

   generate
      if (ADDR_W != VA_W) begin : g_bad_addr_w
         $error("seg_xlate_unit: ADDR_W must equal 32");
      end
      if (PA_W < MIN_PA_W) begin : g_bad_pa_w
         $error("seg_xlate_unit: PA_W too narrow for the base field");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg_word;
   logic [ADDR_W-1:0] off_mask;
   logic [AM_W-1:0]   cfg_am;
   logic              cfg_eu;
   logic [PAF_W-1:0]  cfg_paf;
   xres_e             dec_res;
   logic [PA_W-1:0]   pa_raw;
   logic [2:0]        perm_raw;

   logic              v_c;
   logic [1:0]        res_c;
   logic [PA_W-1:0]   pa_c;
   logic [2:0]        perm_c;

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{cfg_word[8:7], cfg_word[2:0]};

   seg_cfg_select #(.ADDR_W(ADDR_W)) u_sel (
      .va       (virt_addr),
      .cfg0     (seg_cfg0),
      .cfg1     (seg_cfg1),
      .cfg2     (seg_cfg2),
      .cfg_word (cfg_word),
      .off_mask (off_mask)
   );

   assign cfg_paf = cfg_word[PAF_LSB +: PAF_W];
   assign cfg_am  = cfg_word[AM_LSB +: AM_W];
   assign cfg_eu  = cfg_word[EU_BIT];

   seg_am_decode u_dec (
      .priv (priv_mode),
      .am   (cfg_am),
      .eu   (cfg_eu),
      .res  (dec_res)
   );

   seg_pa_compose #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_pa (
      .va       (virt_addr),
      .off_mask (off_mask),
      .pa_field (cfg_paf),
      .res      (dec_res),
      .pa       (pa_raw),
      .perm     (perm_raw)
   );

   // idle cycles present all-zero results
   assign v_c    = in_valid;
   assign res_c  = in_valid ? dec_res  : 2'd0;
   assign pa_c   = in_valid ? pa_raw   : '0;
   assign perm_c = in_valid ? perm_raw : 3'b000;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               result    <= 2'd0;
               phys_addr <= '0;
               perm_rwx  <= 3'b000;
            end else begin
               out_valid <= v_c;
               result    <= res_c;
               phys_addr <= pa_c;
               perm_rwx  <= perm_c;
            end
         end

         a_r11_lat_hi: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         a_r11_lat_lo: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && result == 2'd0));
      end else begin : g_comb
         assign out_valid = v_c;
         assign result    = res_c;
         assign phys_addr = pa_c;
         assign perm_rwx  = perm_c;
      end
   endgenerate

   a_r10_zero_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result != 2'd0) |-> (phys_addr == '0 && perm_rwx == 3'b000));

   a_r9_full_perm: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result == 2'd0) |-> perm_rwx == 3'b111);

   a_r4_kern_no_ade: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && priv_mode == 2'd0) |-> res_c != 2'd2);

   a_r6_user_am5_ade: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && priv_mode == 2'd2 && cfg_am == 3'd5) |-> res_c == 2'd2);

   a_r7_eu_match: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && priv_mode == 2'd3 && cfg_eu) |-> res_c == 2'd0);

endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] virt_addr;
   logic [1:0]  priv_mode;
   logic [31:0] seg_cfg0, seg_cfg1, seg_cfg2;
   logic        out_valid;
   logic [1:0]  result;
   logic [35:0] phys_addr;
   logic [2:0]  perm_rwx;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic        e_valid;
   logic [1:0]  e_res;
   logic [35:0] e_pa;
   logic [2:0]  e_perm;

   always #2.5 clk = ~clk;

   seg_xlate_unit u_seg_xlate_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .virt_addr(virt_addr),
      .priv_mode(priv_mode), .seg_cfg0(seg_cfg0), .seg_cfg1(seg_cfg1),
      .seg_cfg2(seg_cfg2), .out_valid(out_valid), .result(result),
      .phys_addr(phys_addr), .perm_rwx(perm_rwx)
   );

   // behavioural reference of the requirements
   task automatic model(input logic v, input logic [31:0] va, input int pm,
                        input logic [31:0] c0, c1, c2);
      logic [15:0] w;
      longint unsigned msk, base;
      int am;
      bit eu, ade, tlb;
      if (!v) begin
         e_valid = 0; e_res = 0; e_pa = 0; e_perm = 0;
         return;
      end
      if (va < 32'h8000_0000) begin
         msk = 64'h3FFF_FFFF;
         w = (va >= 32'h4000_0000) ? c2[15:0] : c2[31:16];
      end else begin
         msk = 64'h1FFF_FFFF;
         if (va < 32'hA000_0000)      w = c1[31:16];
         else if (va < 32'hC000_0000) w = c1[15:0];
         else if (va < 32'hE000_0000) w = c0[31:16];
         else                         w = c0[15:0];
      end
      am = int'(w[6:4]);
      eu = w[3];
      ade = 0; tlb = 0;
      if (pm == 1) begin
         ade = (am < 2);
         tlb = (am >= 2 && am <= 4);
      end else if (pm == 2) begin
         ade = (am == 0 || am == 1 || am == 2 || am == 5);
         tlb = (am == 3 || am == 4);
      end else if (!(pm == 3 && eu)) begin
         tlb = (am >= 1 && am <= 3);
      end
      e_valid = 1;
      if (ade) begin e_res = 2; e_pa = 0; e_perm = 0; end
      else if (tlb) begin e_res = 1; e_pa = 0; e_perm = 0; end
      else begin
         base = longint'(w[15:9]) * 64'h2000_0000;
         e_res = 0;
         e_pa = 36'((base & ~msk) | (longint'(va) & msk));
         e_perm = 3'b111;
      end
   endtask

   task automatic compare(input string tag);
      checks++;
      if (out_valid !== e_valid || result !== e_res ||
          phys_addr !== e_pa || perm_rwx !== e_perm) begin
         errors++;
         $display("FAIL %s: actual v=%0b res=%0d pa=%h perm=%b expected v=%0b res=%0d pa=%h perm=%b",
                  tag, out_valid, result, phys_addr, perm_rwx,
                  e_valid, e_res, e_pa, e_perm);
      end
   endtask

   // called at a falling edge; result checked one cycle later
   task automatic step(input logic v, input logic [31:0] va, input int pm,
                       input logic [31:0] c0, c1, c2, input string tag);
      in_valid = v; virt_addr = va; priv_mode = 2'(pm);
      seg_cfg0 = c0; seg_cfg1 = c1; seg_cfg2 = c2;
      model(v, va, pm, c0, c1, c2);
      @(negedge clk);
      compare(tag);
   endtask

   function automatic logic [15:0] cw(input int paf, input int am, input bit eu);
      return {7'(paf), 2'b00, 3'(am), eu, 3'b000};
   endfunction

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; in_valid = 1; virt_addr = 32'h1234_5678; priv_mode = 0;
      seg_cfg0 = 0; seg_cfg1 = 0; seg_cfg2 = 0;
      repeat (3) @(negedge clk);
      e_valid = 0; e_res = 0; e_pa = 0; e_perm = 0;
      compare("R12 reset");
      rst_n = 1; in_valid = 0;
      @(negedge clk);
      compare("R12 after reset");

      // R1: lower region halves, distinct bases, both unmapped in kernel
      step(1, 32'h4000_1234, 0, 0, 0, {cw(3,0,0), cw(5,0,0)}, "R1 upper half");
      step(1, 32'h3FFF_FFF0, 0, 0, 0, {cw(3,0,0), cw(5,0,0)}, "R1 lower half");
      // R2: four upper segments with distinct bases
      step(1, 32'h8000_0010, 0, {cw(13,7,0), cw(17,7,0)}, {cw(9,7,0), cw(11,7,0)}, 0, "R2 seg 00");
      step(1, 32'hA000_0020, 0, {cw(13,7,0), cw(17,7,0)}, {cw(9,7,0), cw(11,7,0)}, 0, "R2 seg 01");
      step(1, 32'hC000_0030, 0, {cw(13,7,0), cw(17,7,0)}, {cw(9,7,0), cw(11,7,0)}, 0, "R2 seg 10");
      step(1, 32'hFFFF_FFFF, 0, {cw(13,7,0), cw(17,7,0)}, {cw(9,7,0), cw(11,7,0)}, 0, "R2 seg 11");
      // R3: ignored bits set, result unchanged
      step(1, 32'h0000_0100, 2, 0, 0, {cw(127,7,0) | 16'h0187, 16'h0}, "R3 ignored bits");
      // R4/R5/R6 table corners
      step(1, 32'h9000_0000, 0, 0, {cw(1,2,0), 16'h0}, 0, "R4 kernel tlb");
      step(1, 32'h9000_0000, 0, 0, {cw(1,4,0), 16'h0}, 0, "R4 kernel am4 match");
      step(1, 32'h9000_0000, 1, 0, {cw(1,1,0), 16'h0}, 0, "R5 super ade");
      step(1, 32'h9000_0000, 1, 0, {cw(1,4,0), 16'h0}, 0, "R5 super tlb");
      step(1, 32'h9000_0000, 1, 0, {cw(1,5,0), 16'h0}, 0, "R5 super match");
      step(1, 32'h9000_0000, 2, 0, {cw(1,5,0), 16'h0}, 0, "R6 user am5 ade");
      step(1, 32'h9000_0000, 2, 0, {cw(1,3,0), 16'h0}, 0, "R6 user tlb");
      // R7 error level
      step(1, 32'hE000_0004, 3, {16'h0, cw(2,1,1)}, 0, 0, "R7 eu match");
      step(1, 32'hE000_0004, 3, {16'h0, cw(2,1,0)}, 0, 0, "R7 no eu tlb");
      // R8 reserved mode
      for (int p = 0; p < 4; p++)
         step(1, 32'h0000_4000, p, 0, 0, {cw(6,6,0), 16'h0}, "R8 reserved");
      // R9/R10 compose and zeroing
      step(1, 32'h2345_6789, 0, 0, 0, {cw(127,0,0), 16'h0}, "R9 compose");
      step(1, 32'h2345_6789, 2, 0, 0, {cw(127,0,0), 16'h0}, "R10 zero on ade");
      // R11: idle gap then back-to-back
      step(0, 32'h2345_6789, 0, 0, 0, 0, "R11 idle");
      step(1, 32'h5000_0000, 1, 0, 0, {16'h0, cw(4,7,0)}, "R11 b2b first");
      step(1, 32'h5000_0000, 1, 0, 0, {16'h0, cw(4,3,0)}, "R11 b2b second");

      // sweep of all segments, modes and codes
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 8) != 0, $urandom, int'($urandom % 4),
              $urandom, $urandom, $urandom, "R9 R10 sweep");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule